// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This controller sits beside the fetch and execute logic of a small 16-bit CPU and performs the fixed hardware steps that take the core into an interrupt handler and bring it back out. It watches a vector of request flags and their enables. When the core signals that an instruction has ended, global interrupts are enabled in the live status word and an enabled request is pending, the sequencer takes over. It saves the return address and then the status word on a descending stack. It clears the status word, which drops the global enable and every sleep bit, so a sleeping core wakes. It fetches the handler address of the winning source from a vector table at the top of memory and loads it into the program counter. For sources flagged as single-source it pulses a clear toward the flag.

A return command, issued at an instruction boundary, runs the reverse walk. The saved status word is popped first and then the return address. The restored status word therefore decides the enable and sleep state, whatever the handler did to the live register. Entry and return take a fixed number of cycles.

The memory port is a fixed-latency synchronous port with no back-pressure: a read issued in one cycle returns its data on `mem_rdata` in the next cycle. All other pins are plain control and status signals. The core holds still while `busy` is high and resumes fetching in the cycle `fetch_go` is high.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted only in a cycle where `insn_done` is 1 and the sequencer is idle; with `insn_done` at 0, `busy` stays 0 however long a request is pending.
- R2: Entry writes the program counter to address SP-2, then the status word to SP-4, in consecutive cycles, and leaves the stack pointer at SP-4.
- R3: Among sources with both request and enable set, the one with the highest index is serviced.
- R4: On entry, `irq_clr` pulses the bit of the chosen source only if that bit of SINGLE_MASK is 1; multi-source flags are left set.
- R5: Entry writes the value 0 into the status register.
- R6: The word read from address VEC_BASE + 2*index (VEC_BASE = 0xFFE0) is loaded into the program counter.
- R7: `fetch_go` is high in the sixth cycle after the accepting clock edge, and `busy` is high in all six cycles.
- R8: Return reads the status word from SP, then the program counter from SP+2, leaves the stack pointer at SP+4, and raises `fetch_go` in the fifth cycle after the accepting edge.
- R9: No request is accepted while bit 3 (global enable) of `sr_in` is 0.
- R10: A return command at an instruction boundary is taken before any pending request, and the request is accepted at a later boundary only if the restored status word has bit 3 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NSRC | Pending request flags |
| irq_en | input | NSRC | Per-source enables |
| irq_clr | output | NSRC | One-cycle clear pulse for single-source flags |
| insn_done | input | 1 | Current instruction has completed |
| reti_cmd | input | 1 | Completing instruction is a return-from-interrupt |
| pc_in | input | DW | Live program counter (next instruction) |
| sr_in | input | DW | Live status word |
| sp_in | input | DW | Live stack pointer |
| pc_out | output | DW | New program counter |
| pc_we | output | 1 | Load pc_out |
| sr_out | output | DW | New status word |
| sr_we | output | 1 | Load sr_out |
| sp_out | output | DW | New stack pointer |
| sp_we | output | 1 | Load sp_out |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | DW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after the read |
| busy | output | 1 | Sequence in progress, core stalled |
| fetch_go | output | 1 | Core may fetch at the new program counter |

## Verification
The hardest case is a return command arriving at a boundary while another enabled request is pending and the live status word, altered by the handler, has its global enable set. The bench reaches it by servicing one source, keeping a second flag raised, overwriting the live status word through the core model, and only then issuing the return. It checks that the popped values win, and that the waiting source enters on the following boundary. Priority with a masked higher source and a multi-source flag that must stay set is built the same way from several simultaneous flags.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_E_PUSH_PC, ST_E_PUSH_SR, ST_E_VEC_RD, ST_E_VEC_CAP, ST_E_PC_LD, ST_E_GO,
    ST_R_POP_SR, ST_R_POP_PC, ST_R_PC_LD, ST_R_SETTLE, ST_R_GO
  } seq_state_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NSRC = 16,
  parameter int IW   = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  output logic            any,
  output logic [IW-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i]) idx = IW'(i);
    end
  end

  assign any = |pend;

  AST_PICK_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((pend >> idx) == NSRC'(1))); // R3
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int              NSRC        = 16,
  parameter int              DW          = 16,
  parameter int              IW          = $clog2(NSRC),
  parameter logic [DW-1:0]   VEC_BASE    = 16'hFFE0,
  parameter logic [NSRC-1:0] SINGLE_MASK = 16'h00FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_ent,
  input  logic            start_ret,
  input  logic [IW-1:0]   src_idx,
  input  logic [DW-1:0]   pc_in,
  input  logic [DW-1:0]   sr_in,
  input  logic [DW-1:0]   sp_in,
  input  logic [DW-1:0]   mem_rdata,
  output logic [NSRC-1:0] irq_clr,
  output logic [DW-1:0]   pc_out,
  output logic            pc_we,
  output logic [DW-1:0]   sr_out,
  output logic            sr_we,
  output logic [DW-1:0]   sp_out,
  output logic            sp_we,
  output logic            mem_en,
  output logic            mem_we,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            busy,
  output logic            fetch_go
);
  localparam logic [DW-1:0] WSTEP = DW'(2);

  seq_state_e state_q, state_d;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] pc_q, sr_q, sp_q, vec_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ret)      state_d = ST_R_POP_SR;
        else if (start_ent) state_d = ST_E_PUSH_PC;
      end
      ST_E_PUSH_PC: state_d = ST_E_PUSH_SR;
      ST_E_PUSH_SR: state_d = ST_E_VEC_RD;
      ST_E_VEC_RD:  state_d = ST_E_VEC_CAP;
      ST_E_VEC_CAP: state_d = ST_E_PC_LD;
      ST_E_PC_LD:   state_d = ST_E_GO;
      ST_R_POP_SR:  state_d = ST_R_POP_PC;
      ST_R_POP_PC:  state_d = ST_R_PC_LD;
      ST_R_PC_LD:   state_d = ST_R_SETTLE;
      ST_R_SETTLE:  state_d = ST_R_GO;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pc_q    <= '0;
      sr_q    <= '0;
      sp_q    <= '0;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) begin
        idx_q <= src_idx;
        pc_q  <= pc_in;
        sr_q  <= sr_in;
        sp_q  <= sp_in;
      end
      if (state_q == ST_E_VEC_CAP) vec_q <= mem_rdata;
    end
  end

  always_comb begin
    pc_out = '0; pc_we = 1'b0;
    sr_out = '0; sr_we = 1'b0;
    sp_out = '0; sp_we = 1'b0;
    mem_en = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    unique case (state_q)
      ST_E_PUSH_PC: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = sp_q - WSTEP; mem_wdata = pc_q;
      end
      ST_E_PUSH_SR: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = sp_q - 2 * WSTEP; mem_wdata = sr_q;
        sp_we = 1'b1; sp_out = sp_q - 2 * WSTEP;
      end
      ST_E_VEC_RD: begin
        mem_en = 1'b1;
        mem_addr = VEC_BASE + (DW'(idx_q) << 1);
        sr_we = 1'b1; sr_out = '0;
      end
      ST_E_PC_LD: begin
        pc_we = 1'b1; pc_out = vec_q;
      end
      ST_R_POP_SR: begin
        mem_en = 1'b1; mem_addr = sp_q;
      end
      ST_R_POP_PC: begin
        mem_en = 1'b1; mem_addr = sp_q + WSTEP;
        sr_we = 1'b1; sr_out = mem_rdata;
      end
      ST_R_PC_LD: begin
        pc_we = 1'b1; pc_out = mem_rdata;
        sp_we = 1'b1; sp_out = sp_q + 2 * WSTEP;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_clr
    if (SINGLE_MASK[g]) begin : g_single
      assign irq_clr[g] = (state_q == ST_E_VEC_RD) && (idx_q == IW'(g));
    end else begin : g_multi
      assign irq_clr[g] = 1'b0;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign fetch_go = (state_q == ST_E_GO) || (state_q == ST_R_GO);

  AST_ENTRY_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_E_PUSH_PC) |-> $past(start_ent) && !$past(busy)); // R1
  AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - WSTEP)); // R2
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_clr)); // R4
  AST_CLR_WITH_SR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_clr) |-> (sr_we && sr_out == '0)); // R5
  AST_PC_AFTER_SR: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> ($past(sr_we) || $past(sr_we, 2))); // R8
  AST_ENTRY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_go && state_q == ST_E_GO) |-> $past(start_ent && !busy, 6)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en && !pc_we && !sr_we && !sp_we); // R1
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int              NSRC        = 16,
  parameter int              DW          = 16,
  parameter logic [DW-1:0]   VEC_BASE    = 16'hFFE0,
  parameter int              GIE_BIT     = 3,
  parameter logic [NSRC-1:0] SINGLE_MASK = 16'h00FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_en,
  output logic [NSRC-1:0] irq_clr,
  input  logic            insn_done,
  input  logic            reti_cmd,
  input  logic [DW-1:0]   pc_in,
  input  logic [DW-1:0]   sr_in,
  input  logic [DW-1:0]   sp_in,
  output logic [DW-1:0]   pc_out,
  output logic            pc_we,
  output logic [DW-1:0]   sr_out,
  output logic            sr_we,
  output logic [DW-1:0]   sp_out,
  output logic            sp_we,
  output logic            mem_en,
  output logic            mem_we,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            busy,
  output logic            fetch_go
);
  localparam int IW = $clog2(NSRC);

  logic          any_pend;
  logic [IW-1:0] win_idx;
  logic          start_ent, start_ret;

  irq_prio_pick #(.NSRC(NSRC), .IW(IW)) u_pick (
    .clk  (clk),
    .rst_n(rst_n),
    .pend (irq_req & irq_en),
    .any  (any_pend),
    .idx  (win_idx)
  );

  assign start_ret = insn_done && reti_cmd && !busy;
  assign start_ent = insn_done && !reti_cmd && any_pend && sr_in[GIE_BIT] && !busy;

  irq_seq_ctrl #(
    .NSRC(NSRC), .DW(DW), .IW(IW), .VEC_BASE(VEC_BASE), .SINGLE_MASK(SINGLE_MASK)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ent(start_ent),
    .start_ret(start_ret),
    .src_idx  (win_idx),
    .pc_in    (pc_in),
    .sr_in    (sr_in),
    .sp_in    (sp_in),
    .mem_rdata(mem_rdata),
    .irq_clr  (irq_clr),
    .pc_out   (pc_out),
    .pc_we    (pc_we),
    .sr_out   (sr_out),
    .sr_we    (sr_we),
    .sp_out   (sp_out),
    .sp_we    (sp_we),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .busy     (busy),
    .fetch_go (fetch_go)
  );

  AST_ACCEPT_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(reti_cmd)) |-> ($past(sr_in[GIE_BIT]) && $past(insn_done))); // R9
endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] req, en, irq_clr, sw_set, sw_clr;
  logic insn_done, reti_cmd;
  logic [DW-1:0] pc_r, sr_r, sp_r, pc_out, sr_out, sp_out;
  logic pc_we, sr_we, sp_we, mem_en, mem_we, busy, fetch_go;
  logic [DW-1:0] mem_addr, mem_wdata, mem_rdata;
  logic ld_core;
  logic [DW-1:0] ld_pc, ld_sr, ld_sp;
  logic [DW-1:0] stk [0:127];
  int errors = 0, checks = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(req), .irq_en(en), .irq_clr(irq_clr),
    .insn_done(insn_done), .reti_cmd(reti_cmd),
    .pc_in(pc_r), .sr_in(sr_r), .sp_in(sp_r),
    .pc_out(pc_out), .pc_we(pc_we), .sr_out(sr_out), .sr_we(sr_we),
    .sp_out(sp_out), .sp_we(sp_we),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .fetch_go(fetch_go)
  );

  // core registers, flags and memory model
  always @(posedge clk) begin
    if (!rst_n) begin
      req <= '0; pc_r <= '0; sr_r <= '0; sp_r <= '0;
    end else begin
      req <= (req & ~irq_clr & ~sw_clr) | sw_set;
      if (pc_we) pc_r <= pc_out; else if (ld_core) pc_r <= ld_pc;
      if (sr_we) sr_r <= sr_out; else if (ld_core) sr_r <= ld_sr;
      if (sp_we) sp_r <= sp_out; else if (ld_core) sp_r <= ld_sp;
    end
    if (mem_en && mem_we) stk[mem_addr[7:1]] <= mem_wdata;
    else if (mem_en) begin
      if (mem_addr >= 16'hFFE0) mem_rdata <= 16'hC000 + ((mem_addr - 16'hFFE0) << 3);
      else mem_rdata <= stk[mem_addr[7:1]];
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_core(input logic [DW-1:0] p, input logic [DW-1:0] s, input logic [DW-1:0] q);
    @(negedge clk); ld_core = 1'b1; ld_pc = p; ld_sr = s; ld_sp = q;
    @(negedge clk); ld_core = 1'b0;
  endtask

  task automatic flags(input logic [NSRC-1:0] set_v, input logic [NSRC-1:0] clr_v);
    @(negedge clk); sw_set = set_v; sw_clr = clr_v;
    @(negedge clk); sw_set = '0; sw_clr = '0;
  endtask

  // pulse a boundary, return the cycle in which fetch_go appears, all cycles busy
  task automatic boundary(input logic ret, output int lat, output logic all_busy);
    @(negedge clk); insn_done = 1'b1; reti_cmd = ret;
    lat = 0; all_busy = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk); insn_done = 1'b0; reti_cmd = 1'b0;
      if (!busy) all_busy = 1'b0;
      if (fetch_go) begin lat = k; break; end
    end
  endtask

  task automatic t_reset();
    chk("R1 reset busy", busy, 0);
    chk("R1 reset mem_en", mem_en, 0);
    chk("R4 reset irq_clr", irq_clr, 0);
  endtask

  task automatic t_gating();
    logic seen = 1'b0;
    load_core(16'h1234, 16'h0010, 16'h0100);   // global enable (bit 3) off
    flags(16'h0020, '0);
    @(negedge clk); insn_done = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); insn_done = 1'b0;
      if (busy) seen = 1'b1;
    end
    chk("R9 no accept with enable bit 0", seen, 0);
    load_core(16'h1234, 16'h0018, 16'h0100);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
    end
    chk("R1 no accept without boundary", seen, 0);
    chk("R1 flag still pending", req[5], 1);
  endtask

  task automatic t_entry();
    int lat; logic ab;
    boundary(1'b0, lat, ab);
    chk("R7 entry latency", lat, 6);
    chk("R7 busy throughout", ab, 1);
    chk("R2 pc pushed at sp-2", stk[7'h7F], 16'h1234);
    chk("R2 sr pushed at sp-4", stk[7'h7E], 16'h0018);
    chk("R2 sp after entry", sp_r, 16'h00FC);
    chk("R6 pc from vector 5", pc_r, 16'hC050);
    chk("R5 sr cleared", sr_r, 16'h0000);
    chk("R4 single flag cleared", req[5], 0);
  endtask

  task automatic t_return_first();
    int lat; logic ab;
    flags(16'h0004, '0);                       // source 2 waits
    load_core(16'hC050, 16'h00F8, 16'h00FC);   // handler altered live sr, GIE set
    boundary(1'b1, lat, ab);
    chk("R8 return latency", lat, 5);
    chk("R10 restored sr wins", sr_r, 16'h0018);
    chk("R8 pc restored", pc_r, 16'h1234);
    chk("R8 sp after return", sp_r, 16'h0100);
    chk("R10 pending source not yet taken", req[2], 1);
  endtask

  task automatic t_priority();
    int lat; logic ab;
    en = 16'hEFFF;                             // source 12 masked
    flags(16'h1200, '0);                       // sources 9 and 12
    load_core(16'h2000, 16'h0008, 16'h0100);
    boundary(1'b0, lat, ab);
    chk("R3 highest enabled wins", pc_r, 16'hC090);
    chk("R4 multi-source flag stays", req[9], 1);
    chk("R3 lower flag untouched", req[2], 1);
    chk("R3 masked flag untouched", req[12], 1);
    flags('0, 16'h1200);
    boundary(1'b1, lat, ab);
    chk("R8 return to 2000", pc_r, 16'h2000);
    boundary(1'b0, lat, ab);
    chk("R10 waiting source taken after return", pc_r, 16'hC020);
    chk("R4 source 2 cleared", req[2], 0);
    chk("R2 second push", stk[7'h7F], 16'h2000);
  endtask

  initial begin
    insn_done = 1'b0; reti_cmd = 1'b0; ld_core = 1'b0;
    ld_pc = '0; ld_sr = '0; ld_sp = '0;
    sw_set = '0; sw_clr = '0; en = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gating();
    t_entry();
    t_return_first();
    t_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule